// File: doc/BRIEF.md
# Bus Intercycle Idle Inserter

This block sits between a bus master's request stream and an external memory bus. It decides when the next access may start. Memory is split into numbered areas. Each supported area has a 2-bit idle field in a configuration word. When one bus access is followed by another that needs a turnaround, the block holds the new access for a number of idle clocks before it grants the start.

A turnaround is needed in two cases: the area changes between two accesses, or a read is followed by a write in the same area. The number of idles comes from the field of the area being left. The master raises `req_valid_i` together with an area and a direction, and holds them until it sees `start_o`. `idle_o` is high in every clock that the block spends on idles. The configuration word is written through a plain write strobe.

Top module: `bus_idle_gap`

## Requirements
- R1: The configuration word is 16 bits wide, with the idle field of area n at bits [2n+1:2n]. Areas 0, 2, 3, 4, 5 and 6 are supported. A write with `cfg_we_i` high loads all of their fields on the clock edge. Bits [3:2] and [15:14] have no effect on the idle counts.
- R2: Field codes map to idle counts as follows: 2'b00 gives 1, 2'b01 gives 1, 2'b10 gives 2 and 2'b11 gives 3.
- R3: An access whose area differs from the previous access's area is preceded by as many idles as the field of the previous area gives.
- R4: A write that follows a read in the same area is preceded by the idles of that area's field.
- R5: Within one area, read→read, write→write and write→read get no idles. In those cases `start_o` is high in the same cycle as the request.
- R6: After reset every field is 2'b11. `start_o` and `idle_o` are low, and the first access after reset starts without idles.
- R7: When n idles are due, `idle_o` is high for exactly n cycles, starting with the cycle the request is first presented. `start_o` is low during those cycles and goes high in the cycle after the last idle. `start_o` and `idle_o` are never high together.
- R8: A configuration write that lands while idles are counting leaves the current count unchanged. It applies from the next turnaround onward.
- R9: When the previous access was to an unsupported area (1 or 7), no idles are inserted for any following access.
- R10: `start_o` is only high while `req_valid_i` is high. Each high cycle accepts one access, which becomes the previous access for the next decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration word write strobe |
| cfg_wdata_i | input | 16 | Configuration word, 2 bits per area |
| req_valid_i | input | 1 | Access request, held until granted |
| req_area_i | input | 3 | Area index of the request |
| req_write_i | input | 1 | 1 = write, 0 = read |
| start_o | output | 1 | Access start strobe (grant) |
| idle_o | output | 1 | Idle cycle being inserted |

## Verification
The bench goes after the two codes that both mean one idle. A decoder that reads the raw field value would give zero idles for 2'b00. It also tests which area's field is used on a switch: reading the target area instead of the source area produces different gap lengths on a chain of area changes that all carry distinct fields. A configuration write is made in the middle of a countdown. A design that re-reads the field during the countdown would stretch or cut the gap that is already running. Switches out of areas 1 and 7 and the same-area read, write and write→read pairs must show zero gap, so a design that inserts idles on every access, or on every change of direction, is caught in the very cycle it withholds the start.

// File: rtl/idle_gap_pkg.sv
package idle_gap_pkg;
  localparam int AREA_W = 3;
  localparam int FLD_W  = 2;
  localparam int CNT_W  = 2;

  typedef struct packed {
    logic              vld;
    logic [AREA_W-1:0] area;
    logic              wr;
  } acc_rec_t;

  // 00 and 01 both mean a single idle
  function automatic logic [CNT_W:0] fld_to_idles(input logic [FLD_W-1:0] f);
    case (f)
      2'b10:   fld_to_idles = 3'd2;
      2'b11:   fld_to_idles = 3'd3;
      default: fld_to_idles = 3'd1;
    endcase
  endfunction
endpackage

// File: rtl/idle_cfg_regs.sv
module idle_cfg_regs #(
  parameter int          N_AREAS = 8,
  parameter int          FLD_W   = 2,
  parameter logic [7:0]  SUPPORT = 8'b0111_1101
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       we_i,
  input  logic [N_AREAS*FLD_W-1:0]   wdata_i,
  output logic [N_AREAS*FLD_W-1:0]   fld_o
);
  for (genvar a = 0; a < N_AREAS; a++) begin : g_fld
    if (SUPPORT[a]) begin : g_on
      logic [FLD_W-1:0] fld_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)   fld_q <= '1;
        else if (we_i) fld_q <= wdata_i[a*FLD_W +: FLD_W];
      end
      assign fld_o[a*FLD_W +: FLD_W] = fld_q;
    end else begin : g_off
      assign fld_o[a*FLD_W +: FLD_W] = '0;
    end
  end
endmodule

// File: rtl/idle_need_detect.sv
module idle_need_detect
  import idle_gap_pkg::*;
#(
  parameter int         N_AREAS = 8,
  parameter logic [7:0] SUPPORT = 8'b0111_1101
) (
  input  acc_rec_t                   prev_i,
  input  logic [AREA_W-1:0]          area_i,
  input  logic                       wr_i,
  input  logic [N_AREAS*FLD_W-1:0]   fld_i,
  output logic [CNT_W:0]             idles_o
);
  logic             switch_area;
  logic             rd_to_wr;
  logic [FLD_W-1:0] src_fld;

  assign switch_area = prev_i.area != area_i;
  assign rd_to_wr    = !prev_i.wr && wr_i;
  assign src_fld     = fld_i[prev_i.area*FLD_W +: FLD_W];

  always_comb begin
    idles_o = '0;
    if (prev_i.vld && SUPPORT[prev_i.area] && (switch_area || rd_to_wr))
      idles_o = fld_to_idles(src_fld);
  end
endmodule

// File: rtl/idle_counter.sv
module idle_counter
  import idle_gap_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             grant_i,
  output logic             busy_o,
  output logic             served_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             served_q;

  // served_q: idles for the pending request are already spent
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      served_q <= 1'b0;
    end else begin
      if (load_i)          cnt_q <= load_val_i;
      else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
      if (load_i)          served_q <= 1'b1;
      else if (grant_i)    served_q <= 1'b0;
    end
  end

  assign busy_o   = cnt_q != 0;
  assign served_o = served_q;
  assign cnt_o    = cnt_q;
endmodule

// File: rtl/bus_idle_gap.sv
module bus_idle_gap
  import idle_gap_pkg::*;
#(
  parameter logic [7:0] SUPPORT = 8'b0111_1101
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  cfg_we_i,
  input  logic [15:0]           cfg_wdata_i,
  input  logic                  req_valid_i,
  input  logic [AREA_W-1:0]     req_area_i,
  input  logic                  req_write_i,
  output logic                  start_o,
  output logic                  idle_o
);
  localparam int N_AREAS = 1 << AREA_W;
  localparam int CFG_W   = N_AREAS * FLD_W;

  logic [CFG_W-1:0] fld;
  logic [CNT_W:0]   idles;
  logic             cnt_busy, served, load;
  logic [CNT_W-1:0] cnt_val;
  acc_rec_t         prev_q;

  idle_cfg_regs #(.N_AREAS(N_AREAS), .FLD_W(FLD_W), .SUPPORT(SUPPORT)) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .wdata_i (cfg_wdata_i[CFG_W-1:0]),
    .fld_o   (fld)
  );

  idle_need_detect #(.N_AREAS(N_AREAS), .SUPPORT(SUPPORT)) u_need (
    .prev_i  (prev_q),
    .area_i  (req_area_i),
    .wr_i    (req_write_i),
    .fld_i   (fld),
    .idles_o (idles)
  );

  assign load    = req_valid_i && !cnt_busy && !served && (idles != 0);
  assign start_o = req_valid_i && !cnt_busy && (served || idles == 0);
  assign idle_o  = load || cnt_busy;

  idle_counter u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_val_i (CNT_W'(idles - 1'b1)),
    .grant_i    (start_o),
    .busy_o     (cnt_busy),
    .served_o   (served),
    .cnt_o      (cnt_val)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      prev_q <= '0;
    else if (start_o) prev_q <= '{vld: 1'b1, area: req_area_i, wr: req_write_i};
  end
endmodule

// File: rtl/idle_gap_chk.sv
module idle_gap_chk
  import idle_gap_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic             start_o,
  input logic             idle_o,
  input logic             prev_vld_i,
  input logic [CNT_W-1:0] cnt_i
);
  p_start_excl_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(start_o && idle_o));

  p_start_needs_req_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> req_valid_i);

  p_first_no_gap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !prev_vld_i) |-> start_o);

  p_prev_kept_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> prev_vld_i);

  p_cnt_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_i <= 2'd2);

  p_gap_resolves_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_o && req_valid_i) |=> (idle_o || start_o || !req_valid_i));
endmodule

bind bus_idle_gap idle_gap_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .start_o     (start_o),
  .idle_o      (idle_o),
  .prev_vld_i  (prev_q.vld),
  .cnt_i       (cnt_val)
);

// File: tb/tb_bus_idle_gap.sv
module tb_bus_idle_gap;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [15:0] cfg_wdata_i = '0;
  logic        req_valid_i = 1'b0;
  logic [2:0]  req_area_i = '0;
  logic        req_write_i = 1'b0;
  logic        start_o, idle_o;

  int n_vec = 0, n_err = 0, cyc = 0;
  string tag = "R6";

  bus_idle_gap dut (.*);

  always #2.5 clk_i = ~clk_i;

  // reference model state
  int  m_fld[8];
  int  m_prev_area = 0, m_left = 0;
  bit  m_prev_wr = 0, m_have = 0, m_done = 0;

  function automatic int idl(int f);
    return (f == 2) ? 2 : (f == 3) ? 3 : 1;
  endfunction
  function automatic bit sup(int a);
    return a != 1 && a != 7;
  endfunction

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  endtask

  always @(negedge clk_i) begin
    bit e_st, e_id;
    e_st = 0; e_id = 0;
    cyc++;
    if (cyc > 20000) begin
      n_err++;
      $display("FAIL watchdog expired: actual hang, expected completion");
      finish_run();
    end
    if (rst_ni) begin
      if (m_left > 0) begin
        e_id = 1; m_left--;
      end else if (req_valid_i) begin
        int n;
        n = 0;
        if (m_have && !m_done && sup(m_prev_area) &&
            (m_prev_area != int'(req_area_i) || (!m_prev_wr && req_write_i)))
          n = idl(m_fld[m_prev_area]);
        if (n > 0) begin
          e_id = 1; m_left = n - 1; m_done = 1;
        end else begin
          e_st = 1; m_done = 0; m_have = 1;
          m_prev_area = int'(req_area_i); m_prev_wr = req_write_i;
        end
      end
      n_vec++;
      if (start_o !== e_st || idle_o !== e_id) begin
        n_err++;
        $display("FAIL %s cycle %0d: start/idle actual %b%b expected %b%b",
                 tag, cyc, start_o, idle_o, e_st, e_id);
      end
      if (cfg_we_i)
        for (int a = 0; a < 8; a++) m_fld[a] = int'(cfg_wdata_i[2*a +: 2]);
    end
  end

  task automatic access(input int area, input bit wr, input int exp_gap, input string t);
    int gap;
    gap = 0;
    tag = t;
    @(posedge clk_i); #1;
    req_valid_i = 1; req_area_i = 3'(area); req_write_i = wr;
    forever begin
      @(negedge clk_i);
      if (idle_o) gap++;
      if (start_o) break;
    end
    n_vec++;
    if (gap != exp_gap) begin
      n_err++;
      $display("FAIL %s gap to area %0d wr %0b: actual %0d expected %0d", t, area, wr, gap, exp_gap);
    end
  endtask

  task automatic write_cfg(input logic [15:0] v, input string t);
    tag = t;
    @(posedge clk_i); #1;
    req_valid_i = 0; cfg_we_i = 1; cfg_wdata_i = v;
    @(posedge clk_i); #1;
    cfg_we_i = 0;
  endtask

  initial begin
    for (int a = 0; a < 8; a++) m_fld[a] = 3;
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1;
    @(negedge clk_i);
    n_vec++;
    if (start_o !== 0 || idle_o !== 0) begin
      n_err++;
      $display("FAIL R6 reset outputs: actual %b%b expected 00", start_o, idle_o);
    end
    access(2, 0, 0, "R6");       // first access, no gap
    access(2, 0, 0, "R5");       // read->read
    access(2, 1, 3, "R4");       // read->write, default field 11
    access(2, 1, 0, "R5");       // write->write
    access(2, 0, 0, "R5");       // write->read
    // a7=11 a6=00 a5=10 a4=11 a3=10 a2=01 a1=11 a0=00
    write_cfg(16'hCB9C, "R1");
    access(3, 0, 1, "R2");       // from area 2, code 01
    access(4, 0, 2, "R3");       // from area 3, code 10
    access(0, 1, 3, "R3");       // from area 4, code 11
    access(5, 0, 1, "R2");       // from area 0, code 00
    access(6, 1, 2, "R3");       // from area 5
    access(6, 0, 0, "R5");
    access(6, 1, 1, "R4");       // area 6 code 00
    access(1, 0, 1, "R3");       // into unsupported area, from 6
    access(7, 1, 0, "R9");
    access(1, 0, 0, "R9");
    access(1, 1, 0, "R9");
    access(3, 0, 0, "R9");
    // R8: rewrite fields mid-countdown (area 3 -> 11, area 4 -> 00)
    fork
      access(4, 0, 2, "R8");
      begin
        repeat (2) @(posedge clk_i);
        #1 cfg_we_i = 1; cfg_wdata_i = 16'hC8DC;
        @(posedge clk_i); #1 cfg_we_i = 0;
      end
    join
    access(0, 0, 1, "R8");       // new area 4 field 00 applies
    access(3, 1, 1, "R7");
    access(2, 1, 3, "R7");       // area 3 now 11
    access(2, 1, 0, "R10");
    @(posedge clk_i); #1 req_valid_i = 0; tag = "R10";
    repeat (4) @(posedge clk_i);
    @(negedge clk_i);
    finish_run();
  end
endmodule